// File: doc/BRIEF.md
# DS1 Superframe Transmit Framer

This block serializes a 1.544 Mb/s DS1 line stream in the twelve-frame superframe arrangement. Each frame starts with one framing bit, followed by the channel octets. The block fetches each octet from upstream through a request that is combinational and lasts one cycle. The request names the channel slot it wants, and the octet is taken in that same cycle. The framing bit of each frame is chosen by frame parity. Odd frames carry the terminal-alignment sequence and even frames carry the signaling-alignment sequence.

In the two frames that carry robbed-bit signaling, the last bit of every slot is replaced with a per-channel signaling bit. Frame 6 uses the A bits and frame 12 uses the B bits, and each set is captured when that frame's framing bit goes out. One bit is produced per clock-enable strobe. Each bit comes out together with a valid strobe, a frame-start flag, a superframe-start flag, the frame number and a signaling-frame flag.

Top module: `ds1_sf_tx`

## Requirements
- R1: While reset is asserted and after it is released, every output is 0 until the first `bit_en` strobe. The first bit after reset is the framing bit of frame 1.
- R2: A frame is 193 bits long: one framing bit, then slots 1 to 24 in order, each sent most significant bit first (byte_data[7] first, byte_data[0] last). Every `bit_en` strobe gives one `bit_vld` pulse in the following cycle, carrying that bit.
- R3: `byte_req` is high only in a cycle with `bit_en`. It is high when the framing bit is sent (with `byte_slot`=0) and when the last bit of slot k (k = 1 to 23) is sent (with `byte_slot`=k, zero-based). `byte_data` is captured in that cycle.
- R4: The framing bits of frames 1, 3, 5, 7, 9 and 11 are 1, 0, 1, 0, 1, 0.
- R5: The framing bits of frames 2, 4, 6, 8, 10 and 12 are 0, 0, 1, 1, 1, 0.
- R6: In frame 6 the last bit of slot k is `sig_a[k-1]`. In frame 12 it is `sig_b[k-1]`. In every other frame all eight slot bits are traffic.
- R7: `sig_a` is captured when the framing bit of frame 6 is sent, and `sig_b` when the framing bit of frame 12 is sent. Changes after that capture have no effect within the frame.
- R8: `frame_start` is high with each framing bit and with no other bit. `sf_start` is high only with the framing bit of frame 1.
- R9: `frame_num` gives the frame (1 to 12) of the bit on `ser_bit` and wraps from 12 to 1. `sig_frame` is high for the bits of frames 6 and 12.
- R10: A cycle without `bit_en` advances nothing. `bit_vld`, `frame_start` and `sf_start` are 0 in the following cycle, and the bit sequence continues unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Emit one line bit this cycle |
| byte_data | input | 8 | Octet for the slot named by `byte_slot`, sampled while `byte_req` is high |
| byte_req | output | 1 | Octet fetch strobe (combinational) |
| byte_slot | output | 5 | Zero-based slot index being fetched |
| sig_a | input | 24 | Signaling A bits, bit k for slot k+1 |
| sig_b | input | 24 | Signaling B bits, bit k for slot k+1 |
| ser_bit | output | 1 | Serial line bit |
| bit_vld | output | 1 | `ser_bit` holds a new bit |
| frame_start | output | 1 | Current bit is a framing bit |
| sf_start | output | 1 | Current bit is the framing bit of frame 1 |
| frame_num | output | 4 | Frame number 1 to 12 of the current bit |
| sig_frame | output | 1 | Current bit belongs to frame 6 or 12 |

## Verification
The bench builds the framer with its default 24 slots of 8 bits, so that a full 2316-bit superframe is walked bit by bit in a few thousand strobes. This exercises every framing position of both alignment sequences, the 12-to-1 frame wrap and both signaling frames, and fetches all 24 slot octets several times. Idle gaps between strobes, complemented signaling inputs right after capture, and a reset in the middle of a superframe are also within reach at this size.

// File: rtl/ds1_sf_pkg.sv
package ds1_sf_pkg;

    // Superframe geometry fixed by the line format
    localparam int FRAMES      = 12;
    localparam int FRM_W       = $clog2(FRAMES + 1);
    localparam int SIG_A_FRAME = 6;
    localparam int SIG_B_FRAME = 12;

    // Bit j is the framing value for the j-th odd (terminal) or even (signaling) frame
    localparam logic [5:0] TERM_PAT = 6'b010101;
    localparam logic [5:0] SIGF_PAT = 6'b011100;

    function automatic logic frame_bit(input logic [FRM_W-1:0] frm);
        logic [FRM_W-1:0] k;
        k = (frm - FRM_W'(1)) >> 1;
        return frm[0] ? TERM_PAT[k[2:0]] : SIGF_PAT[k[2:0]];
    endfunction

    function automatic logic is_sig_frame(input logic [FRM_W-1:0] frm);
        return (frm == FRM_W'(SIG_A_FRAME)) || (frm == FRM_W'(SIG_B_FRAME));
    endfunction

endpackage

// File: rtl/ds1_sf_pos.sv
module ds1_sf_pos
    import ds1_sf_pkg::*;
#(
    parameter int SLOTS     = 24,
    parameter int SLOT_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    output logic                          in_f,
    output logic [$clog2(SLOTS)-1:0]      slot,
    output logic [$clog2(SLOT_BITS)-1:0]  bidx,
    output logic [FRM_W-1:0]              frame
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(SLOT_BITS);

    typedef struct packed {
        logic              in_f;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bidx;
        logic [FRM_W-1:0]  frame;
    } pos_t;

    pos_t pos_d, pos_q;
    logic last_bit, last_slot, frame_end;

    always_comb begin
        pos_d     = pos_q;
        last_bit  = (pos_q.bidx == BIT_W'(SLOT_BITS - 1));
        last_slot = (pos_q.slot == SLOT_W'(SLOTS - 1));
        frame_end = !pos_q.in_f && last_bit && last_slot;
        if (bit_en) begin
            if (pos_q.in_f) begin
                pos_d.in_f = 1'b0;
                pos_d.slot = '0;
                pos_d.bidx = '0;
            end else if (last_bit) begin
                pos_d.bidx = '0;
                if (last_slot) begin
                    pos_d.in_f  = 1'b1;
                    pos_d.slot  = '0;
                    pos_d.frame = (pos_q.frame == FRM_W'(FRAMES)) ? FRM_W'(1)
                                                                 : pos_q.frame + FRM_W'(1);
                end else begin
                    pos_d.slot = pos_q.slot + SLOT_W'(1);
                end
            end else begin
                pos_d.bidx = pos_q.bidx + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q.in_f  <= 1'b1;
            pos_q.slot  <= '0;
            pos_q.bidx  <= '0;
            pos_q.frame <= FRM_W'(1);
        end else begin
            pos_q <= pos_d;
        end
    end

    assign in_f  = pos_q.in_f;
    assign slot  = pos_q.slot;
    assign bidx  = pos_q.bidx;
    assign frame = pos_q.frame;

    p_frame_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.frame >= FRM_W'(1)) && (pos_q.frame <= FRM_W'(FRAMES)));

    p_frame_only_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && frame_end) |=> $stable(pos_q.frame));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(pos_q));

    p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.slot <= SLOT_W'(SLOTS - 1));

endmodule

// File: rtl/ds1_sf_slot.sv
module ds1_sf_slot
    import ds1_sf_pkg::*;
#(
    parameter int SLOTS     = 24,
    parameter int SLOT_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    input  logic                          in_f,
    input  logic [$clog2(SLOTS)-1:0]      slot,
    input  logic [$clog2(SLOT_BITS)-1:0]  bidx,
    input  logic [FRM_W-1:0]              frame,
    input  logic [SLOT_BITS-1:0]          byte_data,
    input  logic [SLOTS-1:0]              sig_a,
    input  logic [SLOTS-1:0]              sig_b,
    output logic                          byte_req,
    output logic [$clog2(SLOTS)-1:0]      byte_slot,
    output logic                          data_bit,
    output logic                          sig_frame
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(SLOT_BITS);

    typedef struct packed {
        logic [SLOT_BITS-1:0] oct;
        logic [SLOTS-1:0]     sig;
    } slot_t;

    slot_t st_d, st_q;
    logic  last_bit;
    logic  [BIT_W-1:0] sel;

    always_comb begin
        st_d      = st_q;
        last_bit  = (bidx == BIT_W'(SLOT_BITS - 1));
        sel       = BIT_W'(SLOT_BITS - 1) - bidx;
        sig_frame = is_sig_frame(frame);
        byte_req  = bit_en && (in_f || (last_bit && (slot != SLOT_W'(SLOTS - 1))));
        byte_slot = in_f ? '0 : slot + SLOT_W'(1);
        if (byte_req) begin
            st_d.oct = byte_data;
        end
        if (bit_en && in_f) begin
            if (frame == FRM_W'(SIG_A_FRAME)) begin
                st_d.sig = sig_a;
            end else if (frame == FRM_W'(SIG_B_FRAME)) begin
                st_d.sig = sig_b;
            end
        end
        if (sig_frame && last_bit) begin
            data_bit = st_q.sig[slot];
        end else begin
            data_bit = st_q.oct[sel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_req_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> bit_en);

    p_sig_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && in_f) |=> $stable(st_q.sig));

endmodule

// File: rtl/ds1_sf_tx.sv
module ds1_sf_tx
    import ds1_sf_pkg::*;
#(
    parameter int SLOTS     = 24,
    parameter int SLOT_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    input  logic [SLOT_BITS-1:0]          byte_data,
    output logic                          byte_req,
    output logic [$clog2(SLOTS)-1:0]      byte_slot,
    input  logic [SLOTS-1:0]              sig_a,
    input  logic [SLOTS-1:0]              sig_b,
    output logic                          ser_bit,
    output logic                          bit_vld,
    output logic                          frame_start,
    output logic                          sf_start,
    output logic [FRM_W-1:0]              frame_num,
    output logic                          sig_frame
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(SLOT_BITS);

    typedef struct packed {
        logic             ser;
        logic             vld;
        logic             fstart;
        logic             sfstart;
        logic [FRM_W-1:0] fnum;
        logic             sigf;
    } out_t;

    logic              in_f;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bidx;
    logic [FRM_W-1:0]  frame;
    logic              data_bit;
    logic              cur_sigf;
    out_t              out_d, out_q;

    ds1_sf_pos #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) pos_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .in_f   (in_f),
        .slot   (slot),
        .bidx   (bidx),
        .frame  (frame)
    );

    ds1_sf_slot #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .in_f      (in_f),
        .slot      (slot),
        .bidx      (bidx),
        .frame     (frame),
        .byte_data (byte_data),
        .sig_a     (sig_a),
        .sig_b     (sig_b),
        .byte_req  (byte_req),
        .byte_slot (byte_slot),
        .data_bit  (data_bit),
        .sig_frame (cur_sigf)
    );

    always_comb begin
        out_d         = out_q;
        out_d.vld     = bit_en;
        out_d.fstart  = 1'b0;
        out_d.sfstart = 1'b0;
        if (bit_en) begin
            out_d.ser     = in_f ? frame_bit(frame) : data_bit;
            out_d.fstart  = in_f;
            out_d.sfstart = in_f && (frame == FRM_W'(1));
            out_d.fnum    = frame;
            out_d.sigf    = cur_sigf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ser_bit     = out_q.ser;
    assign bit_vld     = out_q.vld;
    assign frame_start = out_q.fstart;
    assign sf_start    = out_q.sfstart;
    assign frame_num   = out_q.fnum;
    assign sig_frame   = out_q.sigf;

    p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> bit_vld);

    p_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !bit_vld && !frame_start && !sf_start);

    p_sf_in_frame1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start |-> frame_start && (frame_num == FRM_W'(1)));

    p_start_with_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bit_vld);

endmodule

// File: tb/ds1_sf_tx_tb_top.sv
module ds1_sf_tx_tb_top;

    localparam int NSLOT   = 24;
    localparam int FBITS   = 193;
    localparam int SFBITS  = 2316;

    typedef struct packed {
        logic       flip;
        logic [1:0] gap;
        logic [7:0] seed;
        logic [23:0] a;
        logic [23:0] b;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{1'b0, 2'd0, 8'h00, 24'h000000, 24'hFFFFFF},
        '{1'b1, 2'd1, 8'hFF, 24'hFFFFFF, 24'h000000},
        '{1'b1, 2'd2, 8'h5A, 24'hA5C3F0, 24'h0F3C5A},
        '{1'b0, 2'd1, 8'h81, 24'h123456, 24'hFEDCBA}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [7:0]  seed = 8'h00;
    logic [23:0] sig_a = '0;
    logic [23:0] sig_b = '0;
    logic [7:0]  byte_data;
    logic        byte_req;
    logic [4:0]  byte_slot;
    logic        ser_bit, bit_vld, frame_start, sf_start, sig_frame;
    logic [3:0]  frame_num;

    int checks = 0;
    int errors = 0;
    int npos = 0;
    logic [23:0] lat_a = '0;
    logic [23:0] lat_b = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] tb_byte(input logic [7:0] sd, input logic [4:0] s);
        return sd ^ (8'(s) * 8'd29 + 8'd3);
    endfunction

    assign byte_data = tb_byte(seed, byte_slot);

    ds1_sf_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .byte_data   (byte_data),
        .byte_req    (byte_req),
        .byte_slot   (byte_slot),
        .sig_a       (sig_a),
        .sig_b       (sig_b),
        .ser_bit     (ser_bit),
        .bit_vld     (bit_vld),
        .frame_start (frame_start),
        .sf_start    (sf_start),
        .frame_num   (frame_num),
        .sig_frame   (sig_frame)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One strobe at superframe position npos, checked against the requirement model
    task automatic emit();
        int f, p, s, b;
        logic eb, ereq;
        logic [4:0] eslot;
        logic [7:0] oct;
        logic [8:0] exp_v, act_v;
        string tag;
        f = npos / FBITS + 1;
        p = npos % FBITS;
        s = (p - 1) / 8;
        b = (p - 1) % 8;
        @(negedge clk);
        bit_en = 1'b1;
        #1;
        ereq  = (p == 0) || (b == 7 && s < NSLOT - 1);
        eslot = (p == 0) ? 5'd0 : 5'(s + 1);
        if (ereq)
            chk(byte_req && byte_slot == eslot, "R3 fetch", {byte_req, byte_slot}, {ereq, eslot});
        else
            chk(!byte_req, "R3 no fetch", 32'(byte_req), 32'd0);
        if (p == 0 && f == 6)  lat_a = sig_a;
        if (p == 0 && f == 12) lat_b = sig_b;
        if (p == 0) begin
            eb  = (f % 2 == 1) ? (((f - 1) / 2) % 2 == 0) : (f == 6 || f == 8 || f == 10);
            tag = (f % 2 == 1) ? "R4 R8 R9" : "R5 R8 R9";
        end else if (b == 7 && f == 6) begin
            eb = lat_a[s]; tag = "R6 R7";
        end else if (b == 7 && f == 12) begin
            eb = lat_b[s]; tag = "R6 R7";
        end else begin
            oct = tb_byte(seed, 5'(s));
            eb  = oct[7 - b]; tag = "R2 R3 R9";
        end
        @(negedge clk);
        exp_v = {1'b1, eb, (p == 0), (npos == 0), 4'(f), (f == 6 || f == 12)};
        act_v = {bit_vld, ser_bit, frame_start, sf_start, frame_num, sig_frame};
        chk(act_v == exp_v, tag, 32'(act_v), 32'(exp_v));
        bit_en = 1'b0;
        npos = (npos + 1) % SFBITS;
    endtask

    task automatic idle(input int n);
        logic [3:0] fn;
        fn = frame_num;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!bit_vld && !frame_start && !sf_start && frame_num == fn, "R10 idle",
                {bit_vld, frame_start, sf_start, frame_num}, {3'b000, fn});
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs while reset held
        chk({ser_bit, bit_vld, frame_start, sf_start, frame_num, sig_frame, byte_req} == '0,
            "R1 reset", {ser_bit, bit_vld, frame_start, sf_start, frame_num, sig_frame, byte_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ser_bit, bit_vld, frame_start, sf_start, frame_num, sig_frame} == '0,
            "R1 after release", {ser_bit, bit_vld, frame_start, sf_start, frame_num, sig_frame}, 0);

        // Table of superframe runs
        foreach (VEC[v]) begin
            seed  = VEC[v].seed;
            sig_a = VEC[v].a;
            sig_b = VEC[v].b;
            for (int n = 0; n < SFBITS; n++) begin
                emit();
                if (VEC[v].flip && (n == 5 * FBITS || n == 11 * FBITS)) begin
                    sig_a = ~sig_a;   // R7: change after capture must not reach the line
                    sig_b = ~sig_b;
                end
                if (VEC[v].gap != 2'd0) idle(int'(VEC[v].gap));
            end
        end

        // R10: long stall in the middle of frame 3, then continuity
        seed = 8'h3C;
        for (int n = 0; n < 400; n++) emit();
        idle(30);
        for (int n = 0; n < 20; n++) emit();

        // R1: reset in the middle of a superframe restarts at frame 1
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({bit_vld, frame_start, sf_start, frame_num} == '0, "R1 mid reset",
            {bit_vld, frame_start, sf_start, frame_num}, 0);
        rst_n = 1'b1;
        npos = 0;
        for (int n = 0; n < 200; n++) emit();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule